// File: doc/BRIEF.md
# Clocked Programmable Tap Delay Line

This block reproduces a single-bit signal at its output, without inversion, shifted in time by a whole number of sample-clock periods chosen by an 8-bit tap address. The delay is a fixed inherent latency (the `INHERENT` parameter, default 2 clocks) plus the address multiplied by one clock. The structure is a series chain of identical one-clock cells, one for each of the 256 taps. An address-driven selector picks one cell's output, and a final output register follows the selector. Address 0 therefore still takes the inherent latency and never gives a zero delay.

A new address is captured on a `tap_load` strobe. It is not connected to the output at once. The block lowers `delay_valid` and freezes `sig_out` for a settle window of `SETTLE_CYCLES` clocks (default 2^ADDR_W + INHERENT = 258). Only then does it switch the selector to the new tap and resume. This removes any glitch from the tap switch itself, and the line has time to flush stale activity. `tap_addr` has no effect unless `tap_load` is high.

Top module: `tap_delay_line`

## Requirements
- R1: Synchronous active-high `rst` clears every delay cell and the output register, selects tap 0 and sets `delay_valid` to 1. After release `sig_out` reads 0 until an input 1 has travelled through the line.
- R2: With tap 0 selected, a value of `sig_in` sampled at rising edge e appears on `sig_out` after edge e+INHERENT (2 by default), so the minimum delay is not zero.
- R3: With tap A selected and `delay_valid` high, `sig_out` after edge e equals `sig_in` sampled at edge e-INHERENT-A. The output is never inverted, and this holds for long levels, single-clock pulses and random activity.
- R4: The largest address, 255, gives a delay of INHERENT+255 clocks.
- R5: After an edge that samples `tap_load` high, `delay_valid` is 0. It returns to 1 exactly SETTLE_CYCLES edges after that load edge.
- R6: While `delay_valid` is 0, `sig_out` keeps the value it had just after the load edge. Output samples from the new tap begin at the edge after `delay_valid` returns to 1.
- R7: Changes on `tap_addr` while `tap_load` is low affect neither `delay_valid` nor the selected delay.
- R8: A load that arrives during a settle window restarts the full window from that load, and the latest address is the one that takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Signal to be delayed |
| tap_addr | input | ADDR_W (8) | Requested tap address |
| tap_load | input | 1 | Capture strobe for `tap_addr` and start of the settle window |
| sig_out | output | 1 | Registered, delayed copy of `sig_in` |
| delay_valid | output | 1 | High when the selected delay is in effect; low during a settle window |

## Verification
The hardest situation to reach is a tap change while the line is busy: `sig_out` must stay frozen through the whole settle window while `sig_in` keeps toggling, and a second load must arrive partway through a first window. Directed sequences build these cases. One holds the output high and then loads a distant tap while the input is randomised. Another reloads 50 clocks into a window and then times the gap to `delay_valid` and the new latency. A long random run of toggling inputs with sparse random loads then compares every output cycle against a bench model.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

    typedef enum logic {
        TDL_RUN    = 1'b0,
        TDL_SETTLE = 1'b1
    } tdl_state_e;

    function automatic int tdl_tap_count(input int addr_w);
        return 1 << addr_w;
    endfunction

    function automatic int tdl_longest_delay(input int addr_w, input int inherent);
        return (1 << addr_w) - 1 + inherent;
    endfunction

    function automatic int tdl_cnt_width(input int settle);
        return $clog2(settle + 1);
    endfunction

endpackage

// File: rtl/tdl_delay_chain.sv
module tdl_delay_chain #(
    parameter int INHERENT = 2,
    parameter int TAPS     = 256
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            din,
    output logic [TAPS-1:0] taps
);
    logic feed;

    generate
        if (INHERENT > 1) begin : g_front
            localparam int NPRE = INHERENT - 1;
            logic [NPRE-1:0] stage;
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage <= '0;
                end else begin
                    stage[0] <= din;
                    for (int i = 1; i < NPRE; i++) begin
                        stage[i] <= stage[i-1];
                    end
                end
            end
            assign feed = stage[NPRE-1];
        end else begin : g_direct
            assign feed = din;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
        end else begin
            taps <= {taps[TAPS-2:0], feed};
        end
    end

endmodule

// File: rtl/tdl_settle_ctrl.sv
module tdl_settle_ctrl
    import tdl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SETTLE = 258
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] active_addr,
    output logic              valid
);
    localparam int CW = tdl_cnt_width(SETTLE);

    tdl_state_e        state;
    logic [CW-1:0]     cnt;
    logic [ADDR_W-1:0] pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= TDL_RUN;
            cnt         <= '0;
            pending     <= '0;
            active_addr <= '0;
        end else if (load) begin
            pending <= addr_in;
            cnt     <= CW'(SETTLE);
            state   <= TDL_SETTLE;
        end else if (state == TDL_SETTLE) begin
            if (cnt == CW'(1)) begin
                active_addr <= pending;
                state       <= TDL_RUN;
                cnt         <= '0;
            end else begin
                cnt <= cnt - CW'(1);
            end
        end
    end

    assign valid = (state == TDL_RUN);

    // R5: a load always opens a settle window on the next cycle
    assert_load_drops_valid_R5: assert property (@(posedge clk) disable iff (rst)
        load |=> !valid);

    // R5 / R8: the window ends only when its count runs out, with the captured address
    assert_settle_end_R5: assert property (@(posedge clk) disable iff (rst)
        (state == TDL_SETTLE && cnt == CW'(1) && !load) |=> (valid && active_addr == $past(pending)));

    // R7: the requested address is only taken in on a load
    assert_addr_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(pending));

    // R7: the active tap never moves while the block reports a valid delay
    assert_active_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (valid && $past(valid)) |-> $stable(active_addr));

endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line
    import tdl_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int INHERENT      = 2,
    parameter int SETTLE_CYCLES = (1 << ADDR_W) + INHERENT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sig_in,
    input  logic [ADDR_W-1:0] tap_addr,
    input  logic              tap_load,
    output logic              sig_out,
    output logic              delay_valid
);
    localparam int TAPS = tdl_tap_count(ADDR_W);

    logic [TAPS-1:0]   taps;
    logic [ADDR_W-1:0] active_addr;
    logic              tap_bit;

    tdl_delay_chain #(
        .INHERENT (INHERENT),
        .TAPS     (TAPS)
    ) u_chain (
        .clk  (clk),
        .rst  (rst),
        .din  (sig_in),
        .taps (taps)
    );

    tdl_settle_ctrl #(
        .ADDR_W (ADDR_W),
        .SETTLE (SETTLE_CYCLES)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .load        (tap_load),
        .addr_in     (tap_addr),
        .active_addr (active_addr),
        .valid       (delay_valid)
    );

    assign tap_bit = taps[active_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_out <= 1'b0;
        end else if (delay_valid) begin
            sig_out <= tap_bit;
        end
    end

    // R1: reset leaves a cleared output and a valid delay
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (sig_out == 1'b0 && delay_valid));

    // R6: the output is frozen for the whole settle window
    assert_hold_output_R6: assert property (@(posedge clk) disable iff (rst)
        !delay_valid |=> $stable(sig_out));

endmodule

// File: tb/sim_tap_delay_line.sv
`timescale 1ns/1ps
module sim_tap_delay_line;
    localparam int AW  = 8;
    localparam int INH = 2;
    localparam int S   = (1 << AW) + INH;
    localparam int HW  = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sig_in = 1'b0;
    logic tap_load = 1'b0;
    logic [AW-1:0] tap_addr = '0;
    logic sig_out;
    logic delay_valid;

    always #2.5 clk = ~clk;

    tap_delay_line #(.ADDR_W(AW), .INHERENT(INH), .SETTLE_CYCLES(S)) u0 (
        .clk(clk), .rst(rst), .sig_in(sig_in), .tap_addr(tap_addr),
        .tap_load(tap_load), .sig_out(sig_out), .delay_valid(delay_valid)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string phase = "R1";

    bit hist [HW];
    int e_m = HW;
    int act_m = 0;
    int pend_m = 0;
    int cnt_m = 0;
    bit valid_m = 1'b1;
    bit out_m = 1'b0;
    logic [AW-1:0] hold_addr = '0;

    task automatic check_bit(string req, logic act, logic exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic check_int(string req, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one clock: drive, reference update at the edge, compare at the falling edge
    task automatic step(bit din, bit ld, logic [AW-1:0] ad);
        sig_in = din;
        tap_load = ld;
        tap_addr = ad;
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < HW; i++) hist[i] = 1'b0;
            out_m = 1'b0; act_m = 0; pend_m = 0; cnt_m = 0; valid_m = 1'b1;
        end else begin
            e_m++;
            hist[e_m % HW] = din;
            if (valid_m) out_m = hist[(e_m - INH - act_m) % HW];
            if (ld) begin
                pend_m = int'(ad); cnt_m = S; valid_m = 1'b0;
            end else if (cnt_m != 0) begin
                if (cnt_m == 1) begin act_m = pend_m; valid_m = 1'b1; end
                cnt_m--;
            end
        end
        @(negedge clk);
        check_bit(phase, sig_out, out_m, "sig_out vs model");
        check_bit(phase, delay_valid, valid_m, "delay_valid vs model");
    endtask

    task automatic idle(int n);
        repeat (n) step(1'b0, 1'b0, hold_addr);
    endtask

    task automatic do_load(logic [AW-1:0] a, bit din, output int n);
        hold_addr = a;
        step(din, 1'b1, a);
        n = 0;
        while (delay_valid === 1'b0 && n < 2*S) begin
            n++;
            step(din, 1'b0, a);
        end
    endtask

    task automatic measure(output int k);
        step(1'b1, 1'b0, hold_addr);
        k = 0;
        while (sig_out !== 1'b1 && k < 2*S) begin
            k++;
            step(1'b0, 1'b0, hold_addr);
        end
    endtask

    task automatic load_and_time(logic [AW-1:0] a, string req);
        int n, k;
        do_load(a, 1'b0, n);
        check_int("R5", n, S, "settle window length");
        idle(S);
        measure(k);
        check_int(req, k, INH + int'(a), "latency in clocks");
    endtask

    initial begin
        int n, k;
        bit v, stable_ok;
        void'($urandom(32'h5EED_7A9));

        // R1: reset
        repeat (3) step(1'b0, 1'b0, '0);
        rst = 1'b0;
        step(1'b0, 1'b0, '0);
        check_bit("R1", sig_out, 1'b0, "sig_out after reset");
        check_bit("R1", delay_valid, 1'b1, "delay_valid after reset");

        // R2: tap 0 right after reset
        phase = "R2";
        idle(4);
        measure(k);
        check_int("R2", k, INH, "latency at tap 0");

        // R3: levels pass uninverted
        phase = "R3";
        repeat (10) step(1'b1, 1'b0, hold_addr);
        check_bit("R3", sig_out, 1'b1, "high level reproduced");
        idle(10);
        check_bit("R3", sig_out, 1'b0, "low level reproduced");
        load_and_time(8'd1, "R3");
        load_and_time(8'd5, "R3");
        load_and_time(8'd100, "R3");

        // R4: longest delay
        phase = "R4";
        load_and_time(8'd255, "R4");
        load_and_time(8'd0, "R2");

        // R7: address wiggle without load
        phase = "R7";
        load_and_time(8'd5, "R3");
        phase = "R7";
        repeat (20) step(1'b0, 1'b0, AW'($urandom));
        check_bit("R7", delay_valid, 1'b1, "valid after address wiggle");
        idle(S);
        measure(k);
        check_int("R7", k, INH + 5, "latency unchanged by unloaded address");

        // R6: load while output is high, input keeps toggling
        phase = "R6";
        hold_addr = 8'd3;
        repeat (20) step(1'b1, 1'b0, hold_addr);
        step(1'b1, 1'b1, 8'd200);
        hold_addr = 8'd200;
        v = sig_out;
        check_bit("R6", v, 1'b1, "output value at load");
        stable_ok = 1'b1;
        for (int i = 0; i < S - 1; i++) begin
            step(1'($urandom), 1'b0, hold_addr);
            if (sig_out !== v) stable_ok = 1'b0;
        end
        check_bit("R6", stable_ok, 1'b1, "output frozen through settle");
        step(1'b0, 1'b0, hold_addr);
        check_bit("R5", delay_valid, 1'b1, "valid at end of window");
        idle(S);
        measure(k);
        check_int("R6", k, INH + 200, "new tap in effect after window");

        // R8: reload inside a window
        phase = "R8";
        hold_addr = 8'd10;
        step(1'b0, 1'b1, 8'd10);
        idle(50);
        do_load(8'd40, 1'b0, n);
        check_int("R8", n, S, "window restarted by second load");
        idle(S);
        measure(k);
        check_int("R8", k, INH + 40, "latest address wins");

        // R3: random activity with sparse random loads
        phase = "R3";
        for (int i = 0; i < 3000; i++) begin
            bit ld;
            logic [AW-1:0] a;
            ld = ($urandom % 300) == 0;
            a  = ld ? AW'($urandom) : hold_addr;
            if (ld) hold_addr = a;
            step(1'($urandom), ld, a);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule